// File: doc/BRIEF.md
# Multiplexed Parallel Bus Host Sequencer

This block is the host side of an 8-bit, partially multiplexed parallel bus. It carries a 15-bit address. The low address byte and the data byte share eight lanes. The upper seven address bits have pins of their own, which the host always drives. A client hands over one transaction at a time through a valid/ready request port. Each request gives the direction, the address and the write data. When the access is over, the block returns a one-clock done pulse and, for a read, the captured byte.

For each access the sequencer drives the strobes in a fixed order:

- chip select;
- the address on the lanes, with an address-latch pulse;
- the read/write select;
- the enable strobe.

Between phases it turns the shared lanes around. The lanes are split into an output value, an output enable and an input value, so the tri-state buffer sits outside the block.

The address-latch width, the write enable width and the read access wait are clock-count parameters. A repeat request pulses enable again at the address the device already holds, with no latch phase.

Top module: `mpb_host_seq`

## Requirements
- R1: Out of reset, chip select, address latch and enable are low. The lanes are not driven (`bus_ad_oe` = 0), read/write select is high, `req_ready` is high and `done` is low.
- R2: A write runs in this order:
  - chip select high, with the low address byte driven on the lanes while address latch pulses;
  - address latch low for one clock, with the address still driven;
  - read/write select low (0 = write), with the write data replacing the address on the lanes;
  - an enable pulse, during which the write data stays driven and read/write select stays stable.
- R3: A read latches the address the same way. It then releases the lanes and sets read/write select high (1 = read), then raises enable. The lane value is captured on the last clock of the read wait window, and only then. The captured byte appears on `rd_data` while `done` is high.
- R4: The host drives no lane in the clock before a read enable rises. It drives no lane while enable and read/write select are both high. It drives no lane in the clock after enable falls.
- R5: Address latch and enable are never high in the same clock.
- R6: A request with `req_repeat` = 1, made after an access has completed since reset, skips the address latch. Enable is pulsed at the address latched before, and `req_addr` is ignored.
- R7: A request with `req_repeat` = 1 made before any access has completed since reset runs as a full access, with an address latch of `req_addr`.
- R8: Chip select is high whenever address latch or enable is high. In the clock after the `done` clock, chip select is low if `req_valid` was low in the `done` clock. It stays high if `req_valid` was high.
- R9: Address latch stays high for exactly AL_CLKS clocks. Enable stays high for exactly EN_CLKS clocks on a write and exactly RD_WAIT clocks on a read.
- R10: `req_ready` is high only while idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. `done` is high for exactly one clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_repeat | input | 1 | 1 = enable-only access at the held address |
| req_addr | input | 15 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read byte |
| bus_cs | output | 1 | Chip select, active high |
| bus_al | output | 1 | Address latch strobe |
| bus_rw | output | 1 | Read/write select, 1 = read |
| bus_en | output | 1 | Enable strobe |
| bus_addr_hi | output | 7 | Address-only pins, upper address bits |
| bus_ad_out | output | 8 | Value driven onto the shared lanes |
| bus_ad_oe | output | 1 | Lane output enable |
| bus_ad_in | input | 8 | Value seen on the shared lanes |

## Verification
Two things can fall in the same clock: the completion of one access and the arrival of the next request. In that clock the chip-select decision for the following clock is taken while `done` is high. The bench provokes this by holding `req_valid` high through the `done` clock, with new fields already presented, for two consecutive writes followed by a read. It judges the result on three counts. Chip select must not fall between the chained accesses. Each chained access must latch its own address and data at the device model. Chip select must drop exactly once, after the final access, when the request line is released.

// File: rtl/mpb_pkg.sv
// Shared types for the multiplexed parallel bus host sequencer.
package mpb_pkg;
    // Sequencer phases, in bus order.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_SETUP,  // chip select up, address on the lanes
        ST_ALH,    // address latch high
        ST_ALL,    // address latch low, address held
        ST_DIR,    // read/write select set, lanes turned around
        ST_ENA,    // enable high
        ST_REC     // enable low, lanes released, done
    } seq_state_t;

    // What the host puts on the shared lanes.
    typedef enum logic [1:0] {
        LANE_OFF,
        LANE_ADDR,
        LANE_WDATA
    } lane_sel_t;
endpackage

// File: rtl/mpb_timer.sv
// Down counter for phase lengths.
// A load presets the count. The count then falls by one each clock down to
// zero, and expired is high while it reads zero.
// Assumes the loaded value is the phase length minus one.
module mpb_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Load or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mpb_lanes.sv
// Lane driver select for the shared address/data byte lanes.
// Puts the low address byte, the write data or nothing on the lanes.
// Assumes the external tri-state buffer follows ad_oe.
module mpb_lanes
    import mpb_pkg::*;
#(
    parameter int DW = 8
) (
    input  lane_sel_t       sel,
    input  logic [DW-1:0]   addr_lo,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe
);
    // Pick the lane source and the drive enable.
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        case (sel)
            LANE_ADDR:  begin ad_out = addr_lo; ad_oe = 1'b1; end
            LANE_WDATA: begin ad_out = wdata;   ad_oe = 1'b1; end
            default:    begin ad_out = '0;      ad_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mpb_host_seq.sv
// Host sequencer for the multiplexed parallel bus.
// Takes one request at a time. It runs the chip select, address latch,
// read/write select and enable strobes in order, and turns the shared lanes
// around between phases. It returns read data with a one-clock done pulse.
// Assumes the device holds its latched address between accesses, so a
// repeat access can skip the latch phase.
module mpb_host_seq
    import mpb_pkg::*;
#(
    parameter int AW      = 15,
    parameter int DW      = 8,
    parameter int AL_CLKS = 2,
    parameter int EN_CLKS = 2,
    parameter int RD_WAIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_repeat,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic             bus_cs,
    output logic             bus_al,
    output logic             bus_rw,
    output logic             bus_en,
    output logic [AW-DW-1:0] bus_addr_hi,
    output logic [DW-1:0]    bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [DW-1:0]    bus_ad_in
);
    localparam int M1   = (AL_CLKS > EN_CLKS) ? AL_CLKS : EN_CLKS;
    localparam int MAXC = (M1 > RD_WAIT) ? M1 : RD_WAIT;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rd_q;
    logic          wr_q;
    logic          cs_q;
    logic          have_addr_q;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;
    lane_sel_t     lane_sel;
    logic          accept;
    logic          short_path;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign short_path = req_repeat && have_addr_q;

    // Phase length timer.
    mpb_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    // Preset the timer on entry to the address latch and enable phases.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (state_q == ST_SETUP) begin
            t_load = 1'b1;
            t_val  = CW'(AL_CLKS - 1);
        end else if (state_q == ST_DIR) begin
            t_load = 1'b1;
            t_val  = wr_q ? CW'(EN_CLKS - 1) : CW'(RD_WAIT - 1);
        end
    end

    // Next phase.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = short_path ? ST_DIR : ST_SETUP;
            ST_SETUP: state_d = ST_ALH;
            ST_ALH:   if (t_exp) state_d = ST_ALL;
            ST_ALL:   state_d = ST_DIR;
            ST_DIR:   state_d = ST_ENA;
            ST_ENA:   if (t_exp) state_d = ST_REC;
            ST_REC:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, chip select hold and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            wr_q        <= 1'b0;
            cs_q        <= 1'b0;
            have_addr_q <= 1'b0;
            rd_q        <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                cs_q    <= 1'b1;
                if (!short_path) addr_q <= req_addr;
            end else if (state_q == ST_IDLE) begin
                cs_q <= 1'b0;
            end
            if (state_q == ST_REC) begin
                cs_q        <= req_valid;
                have_addr_q <= 1'b1;
            end
            if (state_q == ST_ENA && t_exp && !wr_q)
                rd_q <= bus_ad_in;
        end
    end

    // Lane source per phase.
    always_comb begin
        case (state_q)
            ST_SETUP, ST_ALH, ST_ALL: lane_sel = LANE_ADDR;
            ST_DIR, ST_ENA:           lane_sel = wr_q ? LANE_WDATA : LANE_OFF;
            default:                  lane_sel = LANE_OFF;
        endcase
    end

    // Lane driver.
    mpb_lanes #(.DW(DW)) u_lanes (
        .sel     (lane_sel),
        .addr_lo (addr_q[DW-1:0]),
        .wdata   (wdata_q),
        .ad_out  (bus_ad_out),
        .ad_oe   (bus_ad_oe)
    );

    assign bus_cs      = cs_q;
    assign bus_al      = (state_q == ST_ALH);
    assign bus_en      = (state_q == ST_ENA);
    assign bus_rw      = !(((state_q == ST_DIR) || (state_q == ST_ENA)) && wr_q);
    assign bus_addr_hi = addr_q[AW-1:DW];
    assign req_ready   = (state_q == ST_IDLE);
    assign done        = (state_q == ST_REC);
    assign rd_data     = rd_q;
endmodule

// File: rtl/mpb_host_seq_chk.sv
// Protocol checker for the host sequencer, bound to the top module.
// Watches only ports.
module mpb_host_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic bus_cs,
    input logic bus_al,
    input logic bus_rw,
    input logic bus_en,
    input logic bus_ad_oe
);
    p_al_en_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_al && bus_en));

    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_rw) |-> !bus_ad_oe);

    p_release_before_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_en) && bus_rw) |-> !$past(bus_ad_oe));

    p_idle_after_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_en) |-> !bus_ad_oe);

    p_cs_covers_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_al || bus_en) |-> bus_cs);

    p_rw_steady_in_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && $past(bus_en)) |-> $stable(bus_rw));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_al || bus_en || done) |-> !req_ready);
endmodule

bind mpb_host_seq mpb_host_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_cs    (bus_cs),
    .bus_al    (bus_al),
    .bus_rw    (bus_rw),
    .bus_en    (bus_en),
    .bus_ad_oe (bus_ad_oe)
);

// File: tb/mpb_host_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for the host sequencer, with a simple device model.
module mpb_host_seq_bench;
    localparam int AL_CLKS = 2;
    localparam int EN_CLKS = 2;
    localparam int RD_WAIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_repeat = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rd_data;
    logic        bus_cs, bus_al, bus_rw, bus_en, bus_ad_oe;
    logic [6:0]  bus_addr_hi;
    logic [7:0]  bus_ad_out;
    logic [7:0]  bus_ad_in;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mpb_host_seq #(.AL_CLKS(AL_CLKS), .EN_CLKS(EN_CLKS), .RD_WAIT(RD_WAIT)) u_mpb_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_repeat(req_repeat), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .bus_cs(bus_cs),
        .bus_al(bus_al), .bus_rw(bus_rw), .bus_en(bus_en), .bus_addr_hi(bus_addr_hi),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    function automatic logic [7:0] rmodel(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    // Device model: latched address, write capture, read data after the wait.
    logic [14:0] lat_addr = '0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_last = '0;
    int en_age = 0;
    int al_falls = 0, cs_falls = 0, al_w = 0, en_w = 0, last_al_w = 0, last_en_w = 0;
    int viol_r4 = 0, viol_r5 = 0, viol_r2 = 0;
    logic p_al = 0, p_en = 0, p_cs = 0, p_oe = 0;

    assign bus_ad_in = (bus_en && bus_rw && en_age >= RD_WAIT - 1) ? rmodel(lat_addr) : 8'hEE;

    always @(posedge clk) begin
        if (bus_en && bus_rw) en_age <= en_age + 1;
        else                  en_age <= 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_al && !bus_al) begin
                al_falls++;
                lat_addr = {bus_addr_hi, bus_ad_out};
                if (!bus_ad_oe) viol_r2++;
            end
            if (bus_en && !bus_rw) begin
                wr_last = bus_ad_out;
                wr_addr = lat_addr;
                if (!bus_ad_oe) viol_r2++;
            end
            if (bus_al && bus_en) viol_r5++;
            if (bus_en && bus_rw && bus_ad_oe) viol_r4++;
            if (bus_en && !p_en && bus_rw && p_oe) viol_r4++;
            if (!bus_en && p_en && bus_ad_oe) viol_r4++;
            if (p_cs && !bus_cs) cs_falls++;
            al_w = bus_al ? al_w + 1 : 0;
            en_w = bus_en ? en_w + 1 : 0;
            if (!bus_al && p_al) last_al_w = last_al_w_hold;
            if (!bus_en && p_en) last_en_w = last_en_w_hold;
            last_al_w_hold = al_w;
            last_en_w_hold = en_w;
        end
        p_al = bus_al; p_en = bus_en; p_cs = bus_cs; p_oe = bus_ad_oe;
    end
    int last_al_w_hold = 0, last_en_w_hold = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [7:0] rd_got;

    // One access; returns at the negedge of the done clock (or one later).
    task automatic run(input bit w, input bit rep, input logic [14:0] a,
                       input logic [7:0] d, input bit keep);
        req_write = w; req_repeat = rep; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready while busy", req_ready, 0);
        if (!keep) req_valid = 1'b0;
        while (!done) @(negedge clk);
        rd_got = rd_data;
        req_valid = keep;
        if (!keep) begin
            @(negedge clk);
            chk(done == 1'b0, "R10 done one clock", done, 0);
            #1;
        end
    endtask

    task automatic t_reset;
        chk(bus_cs == 0 && bus_al == 0 && bus_en == 0, "R1 strobes low", {bus_cs, bus_al, bus_en}, 0);
        chk(bus_ad_oe == 0 && bus_rw == 1, "R1 lanes off rw high", {bus_ad_oe, bus_rw}, 1);
        chk(req_ready == 1 && done == 0, "R1 ready idle", {req_ready, done}, 2);
    endtask

    task automatic t_repeat_first;
        int a0;
        a0 = al_falls;
        run(0, 1, 15'h1234, 8'h00, 0);
        chk(al_falls == a0 + 1, "R7 full latch on first repeat", al_falls, a0 + 1);
        chk(rd_got == rmodel(15'h1234), "R7 read data", rd_got, rmodel(15'h1234));
    endtask

    task automatic t_write;
        run(1, 0, 15'h7ABC, 8'h3C, 0);
        chk(wr_last == 8'h3C && wr_addr == 15'h7ABC, "R2 write data/address", {wr_addr, wr_last}, {15'h7ABC, 8'h3C});
        chk(last_al_w == AL_CLKS, "R9 latch width", last_al_w, AL_CLKS);
        chk(last_en_w == EN_CLKS, "R9 write enable width", last_en_w, EN_CLKS);
        chk(bus_cs == 0, "R8 cs low after lone access", bus_cs, 0);
    endtask

    task automatic t_read;
        run(0, 0, 15'h0155, 8'h00, 0);
        chk(rd_got == rmodel(15'h0155), "R3 read data", rd_got, rmodel(15'h0155));
        chk(last_en_w == RD_WAIT, "R9 read enable width", last_en_w, RD_WAIT);
        run(0, 0, 15'h6A0F, 8'h00, 0);
        chk(rd_got == rmodel(15'h6A0F), "R3 read data high address", rd_got, rmodel(15'h6A0F));
    endtask

    task automatic t_repeat;
        int a0;
        a0 = al_falls;
        run(0, 1, 15'h0999, 8'h00, 0);
        chk(al_falls == a0, "R6 no latch on repeat read", al_falls, a0);
        chk(rd_got == rmodel(15'h6A0F), "R6 repeat read uses held address", rd_got, rmodel(15'h6A0F));
        run(1, 1, 15'h0777, 8'hC3, 0);
        chk(al_falls == a0, "R6 no latch on repeat write", al_falls, a0);
        chk(wr_addr == 15'h6A0F && wr_last == 8'hC3, "R6 repeat write at held address", {wr_addr, wr_last}, {15'h6A0F, 8'hC3});
    endtask

    task automatic t_chain;
        int c0;
        #1 c0 = cs_falls;
        run(1, 0, 15'h0111, 8'hA1, 1);
        run(1, 0, 15'h0222, 8'hA2, 1);
        chk(cs_falls == c0, "R8 cs held across chained accesses", cs_falls, c0);
        chk(wr_addr == 15'h0222 && wr_last == 8'hA2, "R8 chained write lands", {wr_addr, wr_last}, {15'h0222, 8'hA2});
        run(0, 0, 15'h0333, 8'h00, 0);
        chk(rd_got == rmodel(15'h0333), "R8 chained read", rd_got, rmodel(15'h0333));
        chk(cs_falls == c0 + 1, "R8 cs drops once at end", cs_falls, c0 + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_repeat_first();
        t_write();
        t_read();
        t_repeat();
        t_chain();
        chk(viol_r4 == 0, "R4 lane turnaround", viol_r4, 0);
        chk(viol_r5 == 0, "R5 latch/enable overlap", viol_r5, 0);
        chk(viol_r2 == 0, "R2 lanes driven in latch and write", viol_r2, 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule